// File: doc/BRIEF.md
# System Timer with Compare Channels

A free-running system timer for a microcontroller peripheral bus. One up-counter, clocked through a programmable prescaler, is shared by four compare channels. Software starts and stops the counter, can load any value into it, and can choose to freeze it while a debugger holds the core halted. Each compare channel holds a compare value and an enable bit. When an enabled channel's compare value and the counter become equal, the channel latches a sticky flag and drives its interrupt request until software writes one to clear the flag.

All state is reached through a flat register port: address, write data, write strobe, read strobe and read data. A read returns the register contents one clock after the read strobe. The register map is: control at 0x00 (bit 0 run, bit 1 freeze during debug halt, bits 15:8 prescale), counter at 0x04, and for channel n (n = 0..3) the channel enable at 0x10+16n (bit 0), the flag at 0x14+16n (bit 0) and the compare value at 0x18+16n.

Top module: `sys_timer`

## Requirements
- R1: After reset every register reads as zero and all interrupt request lines are low.
- R2: With control bit 0 set, the counter advances by one every (prescale+1) clocks, prescale being control bits 15:8; writing the control register restarts the prescale phase.
- R3: With control bit 0 clear, the counter holds its value.
- R4: Writing the counter at 0x04 loads the written value and restarts the prescale phase; the counter wraps from 0xFFFFFFFF to 0 and can be read at any time.
- R5: When control bit 1 is set and dbg_halt is high, the counter holds; with bit 1 clear, dbg_halt has no effect on counting.
- R6: A channel whose enable bit is clear never sets its flag and never raises its request.
- R7: An enabled channel sets its flag on the clock where the counter steps onto its compare value, or where a write to the counter or to its compare value makes the two equal; irq[n] is the channel's flag AND its enable bit.
- R8: Writing a flag register with bit 0 set clears the flag; bit 0 clear leaves it unchanged; when a set event and a clearing write fall on the same clock, the flag ends set.
- R9: bus_rdata presents, one clock after bus_re, the register value at the clock where bus_re was sampled and holds it otherwise; unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Core halted by the debugger |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
Every result of this block lands at the first rising edge after its cause: a counter step, a counter or compare load, a flag set or clear, and the request line all change at that edge, and read data follows one edge after the read strobe. The bench drives inputs on the falling edge, advances its own model at each rising edge, and compares irq and bus_rdata with the model on every falling edge, so each result is checked half a cycle after it is due. Corner cases such as the wrap, the prescale phase and a clear landing on the same edge as a match are timed by counting edges from a counter load, and their values are also checked against literals.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
    // Register map of the timer
    localparam int A_CTRL    = 'h00;
    localparam int A_COUNT   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int OFF_ENA   = 'h0;
    localparam int OFF_FLAG  = 'h4;
    localparam int OFF_CMP   = 'h8;
    // Control field positions
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_FRZ_BIT = 1;
    localparam int CTRL_PS_LSB  = 8;

    function automatic int ch_addr(int idx, int off);
        return CH_BASE + CH_STRIDE * idx + off;
    endfunction
endpackage

// File: rtl/systmr_count.sv
module systmr_count #(
    parameter int DW  = 32,
    parameter int PSW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PSW-1:0] presc,
    input  logic          restart,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cnt_nx,
    output logic          cnt_upd
);
    typedef struct packed {
        logic [PSW-1:0] phase;
        logic [DW-1:0]  cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic    step;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (load) begin
            st_d.cnt   = load_val;
            st_d.phase = '0;
        end else if (restart) begin
            st_d.phase = '0;
        end else if (run) begin
            if (st_q.phase == presc) begin
                st_d.phase = '0;
                st_d.cnt   = st_q.cnt + 1'b1;
                step       = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign cnt_nx  = st_d.cnt;
    assign cnt_upd = step | load;
endmodule

// File: rtl/systmr_chan.sv
module systmr_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ena,
    input  logic          wr_flag,
    input  logic          wr_cmp,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt_nx,
    input  logic          cnt_upd,
    output logic          ena,
    output logic          flag,
    output logic [DW-1:0] cmp,
    output logic          irq
);
    typedef struct packed {
        logic          ena;
        logic          flag;
        logic [DW-1:0] cmp;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic     hit;

    always_comb begin
        st_d = st_q;
        if (wr_ena)            st_d.ena  = wdata[0];
        if (wr_cmp)            st_d.cmp  = wdata;
        if (wr_flag && wdata[0]) st_d.flag = 1'b0;
        // a match event beats a clearing write on the same clock
        hit = st_d.ena && (cnt_upd || wr_cmp) && (cnt_nx == st_d.cmp);
        if (hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena  = st_q.ena;
    assign flag = st_q.flag;
    assign cmp  = st_q.cmp;
    assign irq  = st_q.flag & st_q.ena;
endmodule

// File: rtl/sys_timer.sv
module sys_timer
    import systmr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_we,
    input  logic           bus_re,
    output logic [DW-1:0]  bus_rdata,
    input  logic           dbg_halt,
    output logic [NCH-1:0] irq
);
    typedef struct packed {
        logic [PSW-1:0] presc;
        logic           frz;
        logic           run;
        logic [DW-1:0]  rdata;
    } top_st_t;

    top_st_t st_q, st_d;

    logic            wr_ctrl, wr_count, counting;
    logic [DW-1:0]   cnt_q, cnt_nx;
    logic            cnt_upd;
    logic [NCH-1:0]  ch_ena, ch_flag, ch_wena, ch_wflag, ch_wcmp;
    logic [DW-1:0]   ch_cmp [NCH];
    logic [NCH*DW-1:0] ch_cmp_flat;
    logic [DW-1:0]   rd_val;

    assign wr_ctrl  = bus_we && (bus_addr == AW'(A_CTRL));
    assign wr_count = bus_we && (bus_addr == AW'(A_COUNT));
    assign counting = st_q.run && !(st_q.frz && dbg_halt);

    systmr_count #(.DW(DW), .PSW(PSW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (counting),
        .presc    (st_q.presc),
        .restart  (wr_ctrl),
        .load     (wr_count),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_nx   (cnt_nx),
        .cnt_upd  (cnt_upd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ch_wena[g]  = bus_we && (bus_addr == AW'(ch_addr(g, OFF_ENA)));
        assign ch_wflag[g] = bus_we && (bus_addr == AW'(ch_addr(g, OFF_FLAG)));
        assign ch_wcmp[g]  = bus_we && (bus_addr == AW'(ch_addr(g, OFF_CMP)));
        assign ch_cmp_flat[g*DW +: DW] = ch_cmp[g];

        systmr_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ena  (ch_wena[g]),
            .wr_flag (ch_wflag[g]),
            .wr_cmp  (ch_wcmp[g]),
            .wdata   (bus_wdata),
            .cnt_nx  (cnt_nx),
            .cnt_upd (cnt_upd),
            .ena     (ch_ena[g]),
            .flag    (ch_flag[g]),
            .cmp     (ch_cmp[g]),
            .irq     (irq[g])
        );
    end

    // Read selection
    always_comb begin
        rd_val = '0;
        if (bus_addr == AW'(A_CTRL)) begin
            rd_val[CTRL_RUN_BIT]              = st_q.run;
            rd_val[CTRL_FRZ_BIT]              = st_q.frz;
            rd_val[CTRL_PS_LSB +: PSW]        = st_q.presc;
        end else if (bus_addr == AW'(A_COUNT)) begin
            rd_val = cnt_q;
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(ch_addr(i, OFF_ENA)))  rd_val = {{(DW-1){1'b0}}, ch_ena[i]};
            if (bus_addr == AW'(ch_addr(i, OFF_FLAG))) rd_val = {{(DW-1){1'b0}}, ch_flag[i]};
            if (bus_addr == AW'(ch_addr(i, OFF_CMP)))  rd_val = ch_cmp[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run   = bus_wdata[CTRL_RUN_BIT];
            st_d.frz   = bus_wdata[CTRL_FRZ_BIT];
            st_d.presc = bus_wdata[CTRL_PS_LSB +: PSW];
        end
        if (bus_re) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/sys_timer_chk.sv
module sys_timer_chk #(
    parameter int DW  = 32,
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic            bus_re,
    input logic [DW-1:0]   bus_rdata,
    input logic            dbg_halt,
    input logic            run_bit,
    input logic            frz_bit,
    input logic [DW-1:0]   cnt,
    input logic [NCH-1:0]  flags,
    input logic [NCH*DW-1:0] cmps
);
    // R3: stopped counter keeps its value
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_bit && !bus_we) |=> $stable(cnt));

    // R5: frozen during debug halt
    a_r5_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run_bit && frz_bit && dbg_halt && !bus_we) |=> $stable(cnt));

    // R4: without a write the counter moves by at most one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R9: read data only changes after a read strobe
    a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R7: a flag rises only with counter and compare equal
        a_r7_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[g]) |-> (cnt == cmps[g*DW +: DW]));
        // R8: a flag stays set unless its own register is written
        a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !(bus_we && bus_addr == AW'(20 + 16*g))) |=> flags[g]);
    end
endmodule

bind sys_timer sys_timer_chk #(.DW(DW), .NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .dbg_halt  (dbg_halt),
    .run_bit   (st_q.run),
    .frz_bit   (st_q.frz),
    .cnt       (cnt_q),
    .flags     (ch_flag),
    .cmps      (ch_cmp_flat)
);

// File: tb/sys_timer_test.sv
module sys_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, re = 1'b0, halt = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_re(re), .bus_rdata(rdata), .dbg_halt(halt), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt, m_rd, m_cmp [4];
    logic [7:0]  m_ps;
    logic        m_run, m_frz, m_ena [4], m_flg [4];
    int          m_phase;

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] v = '0;
        if (a == 8'h00) v = {16'h0, m_ps, 6'h0, m_frz, m_run};
        if (a == 8'h04) v = m_cnt;
        for (int i = 0; i < 4; i++) begin
            if (a == 8'(16 + 16*i)) v = {31'h0, m_ena[i]};
            if (a == 8'(20 + 16*i)) v = {31'h0, m_flg[i]};
            if (a == 8'(24 + 16*i)) v = m_cmp[i];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_rd = 0; m_ps = 0; m_run = 0; m_frz = 0; m_phase = 0;
            for (int i = 0; i < 4; i++) begin
                m_cmp[i] = 0; m_ena[i] = 0; m_flg[i] = 0;
            end
        end else begin
            logic [31:0] rv, ncnt;
            logic upd;
            rv = m_read(addr);
            upd = 1'b0;
            ncnt = m_cnt;
            if (we && addr == 8'h04) begin
                ncnt = wdata; m_phase = 0; upd = 1'b1;
            end else if (we && addr == 8'h00) begin
                m_phase = 0;
            end else if (m_run && !(m_frz && halt)) begin
                if (m_phase == int'(m_ps)) begin
                    m_phase = 0; ncnt = m_cnt + 1; upd = 1'b1;
                end else m_phase++;
            end
            if (we && addr == 8'h00) begin
                m_run = wdata[0]; m_frz = wdata[1]; m_ps = wdata[15:8];
            end
            for (int i = 0; i < 4; i++) begin
                if (we && addr == 8'(16 + 16*i)) m_ena[i] = wdata[0];
                if (we && addr == 8'(24 + 16*i)) m_cmp[i] = wdata;
                if (we && addr == 8'(20 + 16*i) && wdata[0]) m_flg[i] = 1'b0;
                if (m_ena[i] && (upd || (we && addr == 8'(24 + 16*i))) && ncnt == m_cmp[i])
                    m_flg[i] = 1'b1;
            end
            m_cnt = ncnt;
            if (re) m_rd = rv;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison, half a cycle after the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 R6 irq lines", {28'h0, irq},
                {28'h0, m_flg[3] & m_ena[3], m_flg[2] & m_ena[2],
                        m_flg[1] & m_ena[1], m_flg[0] & m_ena[0]});
            chk("R9 read data", rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, "R1 control after reset", 32'h0);
        rd(8'h04, "R1 counter after reset", 32'h0);
        rd(8'h14, "R1 flag0 after reset", 32'h0);
        rd(8'h38, "R1 compare2 after reset", 32'h0);
        chk("R1 irq after reset", {28'h0, irq}, 32'h0);

        // R2: divide by one
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h1);
        idle(10);
        rd(8'h04, "R2 counter running", m_read(8'h04));

        // R3: stop holds
        wr(8'h00, 32'h0);
        rd(8'h04, "R3 counter stopped", m_read(8'h04));
        snap = rdata;
        idle(12);
        rd(8'h04, "R3 counter still held", snap);

        // R2: prescale 3 -> divide by 4
        wr(8'h00, 32'h0301);
        wr(8'h04, 32'h0);
        idle(8);
        rd(8'h04, "R2 prescaled count", 32'd2);
        rd(8'h00, "R2 control readback", 32'h0301);

        // R4: load and wrap
        wr(8'h00, 32'h1);
        wr(8'h04, 32'hFFFF_FFFE);
        idle(3);
        rd(8'h04, "R4 wrap through zero", 32'd1);

        // R7 / R6: channel 0 enabled, channel 1 disabled, same compare
        wr(8'h18, 32'd20);
        wr(8'h10, 32'h1);
        wr(8'h28, 32'd20);
        wr(8'h04, 32'd0);
        idle(30);
        chk("R7 irq0 raised", {31'h0, irq[0]}, 32'h1);
        chk("R6 irq1 stays low", {31'h0, irq[1]}, 32'h0);
        rd(8'h24, "R6 disabled flag1 clear", 32'h0);

        // R8: write zero keeps, write one clears
        wr(8'h14, 32'h0);
        rd(8'h14, "R8 write 0 keeps flag0", 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h14, "R8 write 1 clears flag0", 32'h0);

        // R8: set wins over a same-clock clear (counter reaches 105 on 5th edge)
        wr(8'h38, 32'd105);
        wr(8'h30, 32'h1);
        wr(8'h04, 32'd100);
        idle(4);
        wr(8'h34, 32'h1);
        rd(8'h34, "R8 set beats clear", 32'h1);
        wr(8'h34, 32'h1);

        // R7: compare write making values equal on a stopped counter
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd500);
        wr(8'h40, 32'h1);
        wr(8'h48, 32'd500);
        rd(8'h44, "R7 compare write sets flag3", 32'h1);
        chk("R7 irq3 raised", {31'h0, irq[3]}, 32'h1);
        wr(8'h40, 32'h0);
        chk("R7 irq3 masked by enable", {31'h0, irq[3]}, 32'h0);

        // R5: freeze during halt, and halt ignored without freeze
        wr(8'h04, 32'd0);
        halt = 1'b1;
        wr(8'h00, 32'h3);
        idle(10);
        rd(8'h04, "R5 frozen while halted", 32'd0);
        wr(8'h00, 32'h1);
        idle(10);
        rd(8'h04, "R5 halt ignored without freeze", m_read(8'h04));
        halt = 1'b0;

        // R9: unmapped address reads zero, write ignored
        wr(8'h0C, 32'hDEAD_BEEF);
        rd(8'h0C, "R9 unmapped reads zero", 32'h0);
        rd(8'h00, "R9 control unchanged", 32'h1);

        idle(5);
        finish_run();
    end
endmodule